// File: doc/BRIEF.md
# Guarded Nonvolatile Byte Store Controller

This block sits between a CPU register bus and a small byte-wide nonvolatile array. The array is modelled as a bank of flops. Software loads a cell address and a data byte into two registers. It then drives reads and program operations through one control register. A program operation runs for a fixed number of clock cycles that depends on its mode. While it runs, the program-enable bit reads back as one.

A program operation has to be unlocked first. Software writes the unlock bit, and then, in a later write while that bit is still set, it writes the program-enable bit. The unlock bit clears itself a few cycles after it is written, so a stray single write cannot start an operation. The block asks the CPU to stall for a short fixed time after each read and after each program start. It also raises a level interrupt while its interrupt enable is set and the array is idle.

There are two resets. The power-on reset clears everything, including a program operation that is running. The system reset clears only the bus-side registers, and a program operation already running goes on until it commits.

Top module: `eectl_top`

## Requirements
- R1: Register offset 0 holds the cell address, offset 1 holds the data byte, offset 2 is the control register and offset 3 reads zero. The control register bits are:
  - bit 0: read strobe, always reads 0.
  - bit 1: program enable, which is also the busy flag.
  - bit 2: unlock.
  - bit 3: ready-interrupt enable.
  - bits 5:4: mode. 00 is erase then write, 01 is erase only, 10 is write only and 11 is reserved.
- R2: Writing a one to control bit 2 sets the unlock bit. It reads one for exactly 4 cycles after that write and then clears by itself. Writing it again restarts the 4-cycle window.
- R3: A control write with bit 1 set starts an operation only when all of these hold: the unlock bit was already set before this write, no operation is running, and the written mode is not 11. Otherwise the write leaves the busy flag at zero.
- R4: Erase-then-write stores the data byte held at the start into the addressed cell. The busy flag stays set for T_EW cycles (default 34) and then clears.
- R5: Erase only sets the cell to 0xFF after T_ER cycles. Write only stores the old cell value ANDed with the data byte after T_WR cycles. T_ER and T_WR both default to 18.
- R6: The stall output is high for 4 cycles after an accepted read strobe and for 2 cycles after a program start.
- R7: The ready interrupt is high exactly when its enable is set and no operation is running.
- R8: While an operation runs, writes to the address register are ignored, writes to the mode field are ignored, and read strobes are ignored. An ignored read strobe leaves the data byte unchanged and does not stall the CPU.
- R9: A read strobe accepted while idle loads the data register with the addressed cell in the cycle after the write.
- R10: The system reset clears the address, data, interrupt enable, unlock, stall and mode. An operation already running still completes and commits. Until it finishes, the mode field shows the running operation's mode, and after that it reads 00.
- R11: The power-on reset clears all state, including a running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the register at reg_addr |
| cpu_stall | output | 1 | CPU halt request |
| ready_irq | output | 1 | Level interrupt: enabled and idle |

## Verification
Several functions can fall in the same cycle, and the bench provokes each such case on purpose:
- A program-enable write lands in the same write as the unlock bit.
- A program-enable write lands exactly on the last cycle of the unlock window, and on the cycle just after it.
- Address writes, mode writes and read strobes are issued while an operation is counting down.
- The system reset is pulsed while an operation is still running.

The bench keeps a behavioural reference model that runs cycle by cycle. The model is compared with the stall output, the interrupt output and the selected register on every clock. Directed reads then confirm each cell value that was committed.

// File: rtl/eectl_pkg.sv
package eectl_pkg;
  typedef enum logic [1:0] {
    PM_ERASE_WRITE = 2'b00,
    PM_ERASE_ONLY  = 2'b01,
    PM_WRITE_ONLY  = 2'b10,
    PM_RESERVED    = 2'b11
  } pmode_e;

  localparam int CB_READ  = 0;
  localparam int CB_PROG  = 1;
  localparam int CB_ARM   = 2;
  localparam int CB_IRQEN = 3;
  localparam int CB_MODE  = 4;

  localparam logic [1:0] RA_ADDR = 2'd0;
  localparam logic [1:0] RA_DATA = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
endpackage

// File: rtl/eectl_rsync.sv
module eectl_rsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/eectl_unlock.sv
module eectl_unlock #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  output logic armed
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (arm_set)             cnt_d = CW'(WINDOW);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign armed = (cnt_q != '0);

  // R2: the unlock bit appears only after a write of the unlock bit
  assert_arm_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(arm_set));
  // R2: a write of the unlock bit always leaves it set in the next cycle
  assert_arm_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_set |=> armed);
endmodule

// File: rtl/eectl_engine.sv
module eectl_engine
  import eectl_pkg::*;
#(
  parameter int AW   = 6,
  parameter int DW   = 8,
  parameter int T_EW = 34,
  parameter int T_ER = 18,
  parameter int T_WR = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  pmode_e        start_mode,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_data,
  input  logic [DW-1:0] old_byte,
  output logic          busy,
  output pmode_e        op_mode,
  output logic [AW-1:0] op_addr,
  output logic          commit,
  output logic [DW-1:0] commit_data
);
  localparam int TMAX = (T_EW > T_ER) ? ((T_EW > T_WR) ? T_EW : T_WR)
                                      : ((T_ER > T_WR) ? T_ER : T_WR);
  localparam int CW = $clog2(TMAX + 1);

  function automatic logic [CW-1:0] dur(input pmode_e m);
    case (m)
      PM_ERASE_ONLY: dur = CW'(T_ER);
      PM_WRITE_ONLY: dur = CW'(T_WR);
      default:       dur = CW'(T_EW);
    endcase
  endfunction

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  pmode_e        mode_q, mode_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    addr_d = addr_q;
    data_d = data_q;
    commit = 1'b0;
    if (busy_q) begin
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        commit = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = dur(start_mode);
      mode_d = start_mode;
      addr_d = start_addr;
      data_d = start_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= PM_ERASE_WRITE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    case (mode_q)
      PM_ERASE_ONLY: commit_data = '1;
      PM_WRITE_ONLY: commit_data = old_byte & data_q;
      default:       commit_data = data_q;
    endcase
  end

  assign busy    = busy_q;
  assign op_mode = mode_q;
  assign op_addr = addr_q;

  // R4: the busy flag only drops on the cycle that commits the cell
  assert_busy_ends_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(commit));
  // R3: the reserved mode never runs
  assert_no_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (op_mode != PM_RESERVED));
  // R5: a commit happens only inside a running operation
  assert_commit_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> busy);
endmodule

// File: rtl/eectl_array.sv
module eectl_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_w [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    logic          hit;
    logic [DW-1:0] word_q;
    assign hit = we && (waddr == AW'(gi));
    always_ff @(posedge clk) begin
      if (hit) word_q <= wdata;
    end
    assign cell_w[gi] = word_q;
  end

  assign rdata_a = cell_w[raddr_a];
  assign rdata_b = cell_w[raddr_b];
endmodule

// File: rtl/eectl_top.sv
module eectl_top
  import eectl_pkg::*;
#(
  parameter int AW         = 6,
  parameter int T_EW       = 34,
  parameter int T_ER       = 18,
  parameter int T_WR       = 18,
  parameter int UNLOCK_WIN = 4,
  parameter int RD_STALL   = 4,
  parameter int PG_STALL   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       cpu_stall,
  output logic       ready_irq
);
  localparam int DW   = 8;
  localparam int SMAX = (RD_STALL > PG_STALL) ? RD_STALL : PG_STALL;
  localparam int SW   = $clog2(SMAX + 1);

  logic bus_rst_n, eng_rst_n, bus_arst_n;
  assign bus_arst_n = rst_n & por_n;

  eectl_rsync u_sync_bus (.clk(clk), .arst_n(bus_arst_n), .srst_n(bus_rst_n));
  eectl_rsync u_sync_eng (.clk(clk), .arst_n(por_n),      .srst_n(eng_rst_n));

  logic          addr_wr, data_wr, ctrl_wr;
  logic          armed, busy, start, rd_do, commit;
  pmode_e        wmode, op_mode, vis_mode;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] rd_byte, old_byte, commit_data;

  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          irqen_q, irqen_d;
  pmode_e        mode_q, mode_d;
  logic [SW-1:0] stall_q, stall_d;

  assign addr_wr = reg_wr && (reg_addr == RA_ADDR);
  assign data_wr = reg_wr && (reg_addr == RA_DATA);
  assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
  assign wmode   = pmode_e'(reg_wdata[CB_MODE +: 2]);

  eectl_unlock #(.WINDOW(UNLOCK_WIN)) u_unlock (
    .clk     (clk),
    .rst_n   (bus_rst_n),
    .arm_set (ctrl_wr && reg_wdata[CB_ARM]),
    .armed   (armed)
  );

  assign start = ctrl_wr && reg_wdata[CB_PROG] && armed && !busy
                 && (wmode != PM_RESERVED);
  assign rd_do = ctrl_wr && reg_wdata[CB_READ] && !busy && !start;

  eectl_engine #(
    .AW(AW), .DW(DW), .T_EW(T_EW), .T_ER(T_ER), .T_WR(T_WR)
  ) u_engine (
    .clk         (clk),
    .rst_n       (eng_rst_n),
    .start       (start),
    .start_mode  (wmode),
    .start_addr  (addr_q),
    .start_data  (data_q),
    .old_byte    (old_byte),
    .busy        (busy),
    .op_mode     (op_mode),
    .op_addr     (op_addr),
    .commit      (commit),
    .commit_data (commit_data)
  );

  eectl_array #(.AW(AW), .DW(DW)) u_array (
    .clk     (clk),
    .we      (commit),
    .waddr   (op_addr),
    .wdata   (commit_data),
    .raddr_a (addr_q),
    .rdata_a (rd_byte),
    .raddr_b (op_addr),
    .rdata_b (old_byte)
  );

  always_comb begin
    addr_d  = addr_q;
    data_d  = data_q;
    irqen_d = irqen_q;
    mode_d  = mode_q;
    stall_d = stall_q;
    if (addr_wr && !busy) addr_d = reg_wdata[AW-1:0];
    if (rd_do)            data_d = rd_byte;
    else if (data_wr)     data_d = reg_wdata;
    if (ctrl_wr) begin
      irqen_d = reg_wdata[CB_IRQEN];
      if (!busy) mode_d = wmode;
    end
    if (start)                stall_d = SW'(PG_STALL);
    else if (rd_do)           stall_d = SW'(RD_STALL);
    else if (stall_q != '0)   stall_d = stall_q - 1'b1;
  end

  always_ff @(posedge clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      irqen_q <= 1'b0;
      mode_q  <= PM_ERASE_WRITE;
      stall_q <= '0;
    end else begin
      addr_q  <= addr_d;
      data_q  <= data_d;
      irqen_q <= irqen_d;
      mode_q  <= mode_d;
      stall_q <= stall_d;
    end
  end

  assign vis_mode = busy ? op_mode : mode_q;

  always_comb begin
    case (reg_addr)
      RA_ADDR: reg_rdata = 8'(addr_q);
      RA_DATA: reg_rdata = data_q;
      RA_CTRL: reg_rdata = {2'b00, vis_mode, irqen_q, armed, busy, 1'b0};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign cpu_stall = (stall_q != '0);
  assign ready_irq = irqen_q && !busy;

  // R6: an accepted read or program start raises the stall request next cycle
  assert_stall_read_R6: assert property (@(posedge clk) disable iff (!bus_rst_n || !eng_rst_n)
    rd_do |=> cpu_stall);
  assert_stall_prog_R6: assert property (@(posedge clk) disable iff (!bus_rst_n || !eng_rst_n)
    start |=> cpu_stall);
  // R3: an accepted start makes the engine busy in the next cycle
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!bus_rst_n || !eng_rst_n)
    start |=> busy);
  // R7: no ready interrupt while an operation runs
  assert_irq_idle_R7: assert property (@(posedge clk) disable iff (!bus_rst_n || !eng_rst_n)
    busy |-> !ready_irq);
  // R8: the cell address holds still across a running operation
  assert_addr_locked_R8: assert property (@(posedge clk) disable iff (!bus_rst_n || !eng_rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));
endmodule

// File: tb/tb_eectl_top.sv
`timescale 1ns/1ps
module tb_eectl_top;
  localparam int AW = 6, T_EW = 34, T_ER = 18, T_WR = 18;
  localparam logic [1:0] A_ADDR = 2'd0, A_DATA = 2'd1, A_CTRL = 2'd2;
  localparam logic [7:0] RD = 8'h01, PG = 8'h02, ARM = 8'h04, IE = 8'h08;
  localparam logic [7:0] M_ER = 8'h10, M_WR = 8'h20, M_RS = 8'h30;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, por_n, reg_wr, cpu_stall, ready_irq;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  eectl_top #(.AW(AW), .T_EW(T_EW), .T_ER(T_ER), .T_WR(T_WR)) dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_stall(cpu_stall), .ready_irq(ready_irq));

  int vectors = 0, errors = 0, cyc = 0;
  bit cmp_on = 0;

  // reference model state
  logic [AW-1:0] m_addr, m_opaddr;
  logic [7:0]    m_data, m_opdata;
  logic          m_ie, m_busy;
  logic [1:0]    m_mode, m_opmode, p_s, r_s;
  int            m_arm, m_stall, m_cnt;
  logic [7:0]    m_mem [1 << AW];

  task automatic model_bus_reset();
    m_addr = '0; m_data = 8'h00; m_ie = 1'b0; m_mode = 2'b00;
    m_arm = 0; m_stall = 0;
  endtask

  always @(negedge por_n) begin
    p_s = 2'b00; r_s = 2'b00; model_bus_reset();
    m_busy = 1'b0; m_cnt = 0; m_opmode = 2'b00; m_opaddr = '0; m_opdata = 8'h00;
  end

  always @(negedge rst_n) begin
    r_s = 2'b00; model_bus_reset();
  end

  always @(posedge clk) begin : model
    logic eng_ok, bus_ok, o_busy, st;
    int o_arm;
    logic [7:0] w;
    eng_ok = p_s[1]; bus_ok = r_s[1];
    p_s = {p_s[0], por_n};
    r_s = {r_s[0], por_n & rst_n};
    o_busy = m_busy; o_arm = m_arm; w = reg_wdata;
    if (eng_ok && m_busy) begin
      if (m_cnt == 1) begin
        m_busy = 1'b0;
        case (m_opmode)
          2'b01:   m_mem[m_opaddr] = 8'hFF;
          2'b10:   m_mem[m_opaddr] = m_mem[m_opaddr] & m_opdata;
          default: m_mem[m_opaddr] = m_opdata;
        endcase
      end else m_cnt = m_cnt - 1;
    end
    if (bus_ok) begin
      if (m_arm > 0) m_arm = m_arm - 1;
      if (m_stall > 0) m_stall = m_stall - 1;
      if (reg_wr) begin
        case (reg_addr)
          A_ADDR: if (!o_busy) m_addr = w[AW-1:0];
          A_DATA: m_data = w;
          A_CTRL: begin
            m_ie = w[3];
            if (w[2]) m_arm = 4;
            st = w[1] && (o_arm > 0) && !o_busy && (w[5:4] != 2'b11);
            if (!o_busy) m_mode = w[5:4];
            if (st) begin
              m_busy = 1'b1; m_opmode = w[5:4]; m_opaddr = m_addr; m_opdata = m_data;
              m_cnt = (w[5:4] == 2'b01) ? T_ER : (w[5:4] == 2'b10) ? T_WR : T_EW;
              m_stall = 2;
            end else if (w[0] && !o_busy) begin
              m_data = m_mem[m_addr];
              m_stall = 4;
            end
          end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rdata(input logic [1:0] a);
    case (a)
      A_ADDR:  return 8'(m_addr);
      A_DATA:  return m_data;
      A_CTRL:  return {2'b00, (m_busy ? m_opmode : m_mode), m_ie, (m_arm > 0), m_busy, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R6 stall", {7'b0, cpu_stall}, {7'b0, (m_stall > 0)});
      chk("R7 irq", {7'b0, ready_irq}, {7'b0, (m_ie && !m_busy)});
      case (reg_addr)
        A_ADDR:  chk("R8 addr reg", reg_rdata, exp_rdata(reg_addr));
        A_DATA:  chk("R9 data reg", reg_rdata, exp_rdata(reg_addr));
        default: chk("R1 ctrl reg", reg_rdata, exp_rdata(reg_addr));
      endcase
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R1 watchdog: got hang expected completion");
      summary();
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      reg_addr = reg_addr + 2'd1;
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 200; i++) begin
      peek(A_CTRL, v);
      if (!v[1]) return;
    end
    chk("R4 busy timeout", 8'h01, 8'h00);
  endtask

  task automatic read_cell(input logic [AW-1:0] a, output logic [7:0] v);
    wr(A_ADDR, 8'(a));
    wr(A_CTRL, IE | RD);
    peek(A_DATA, v);
  endtask

  task automatic arm_prog(input logic [7:0] mode);
    wr(A_CTRL, IE | ARM);
    wr(A_CTRL, IE | PG | mode);
  endtask

  initial begin
    logic [7:0] v;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    por_n = 1'b1; rst_n = 1'b1;
    #1 por_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); cmp_on = 1;
    repeat (3) @(negedge clk);
    #1 por_n = 1'b1; rst_n = 1'b1;
    idle(4);
    // R11 reset state
    peek(A_CTRL, v); chk("R11 ctrl after power-on", v, 8'h00);
    peek(A_ADDR, v); chk("R11 addr after power-on", v, 8'h00);
    peek(3'd3, v);   chk("R1 unused offset", v, 8'h00);
    // R7 interrupt when enabled and idle
    wr(A_CTRL, IE); idle(1);
    chk("R7 irq idle", {7'b0, ready_irq}, 8'h01);
    // R5 erase only on cell 5
    wr(A_ADDR, 8'd5);
    arm_prog(M_ER);
    peek(A_CTRL, v); chk("R3 busy after unlock+start", {7'b0, v[1]}, 8'h01);
    chk("R7 irq low while busy", {7'b0, ready_irq}, 8'h00);
    wait_idle();
    read_cell(6'd5, v); chk("R5 erase gives FF", v, 8'hFF);
    // R4 erase+write
    wr(A_DATA, 8'hA5); arm_prog(8'h00); wait_idle();
    read_cell(6'd5, v); chk("R4 erase-write value", v, 8'hA5);
    // R5 write only ANDs
    wr(A_DATA, 8'h3C); arm_prog(M_WR); wait_idle();
    read_cell(6'd5, v); chk("R5 write-only AND", v, 8'h24);
    // R3 start without unlock
    wr(A_CTRL, IE | PG); peek(A_CTRL, v);
    chk("R3 no unlock", {7'b0, v[1]}, 8'h00);
    // R3 unlock and start in one write
    wr(A_CTRL, IE | ARM | PG); peek(A_CTRL, v);
    chk("R3 same-write unlock", {7'b0, v[1]}, 8'h00);
    idle(6);
    // R2 window expired (fifth cycle)
    wr(A_CTRL, IE | ARM); idle(3); wr(A_CTRL, IE | PG);
    peek(A_CTRL, v); chk("R2 expired window", {7'b0, v[1]}, 8'h00);
    // R2 window boundary (fourth cycle) starts erase+write of cell 9
    wr(A_ADDR, 8'd9); wr(A_DATA, 8'h5A);
    wr(A_CTRL, IE | ARM); idle(2); wr(A_CTRL, IE | PG);
    peek(A_CTRL, v); chk("R2 last window cycle", {7'b0, v[1]}, 8'h01);
    wait_idle();
    read_cell(6'd9, v); chk("R4 boundary commit", v, 8'h5A);
    // R3 reserved mode
    arm_prog(M_RS); peek(A_CTRL, v);
    chk("R3 reserved mode", {7'b0, v[1]}, 8'h00);
    idle(6);
    // R8 lockout while busy
    wr(A_DATA, 8'h11); arm_prog(8'h00);
    wr(A_ADDR, 8'd2);
    wr(A_CTRL, IE | RD | M_ER);
    peek(A_ADDR, v); chk("R8 addr locked", v, 8'h09);
    peek(A_DATA, v); chk("R8 read ignored", v, 8'h11);
    peek(A_CTRL, v); chk("R8 mode locked", {6'b0, v[5:4]}, 8'h00);
    wait_idle();
    read_cell(6'd9, v); chk("R9 read back", v, 8'h11);
    // R10 system reset during erase of cell 12
    wr(A_ADDR, 8'd12); arm_prog(M_ER); idle(3);
    @(negedge clk); #1 rst_n = 1'b0;
    idle(2);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(3);
    peek(A_CTRL, v); chk("R10 op survives reset", v, 8'h12);
    wait_idle();
    peek(A_CTRL, v); chk("R10 mode back to 00", v, 8'h00);
    read_cell(6'd12, v); chk("R10 commit completed", v, 8'hFF);
    // R11 power-on reset aborts an operation
    arm_prog(8'h00); idle(3);
    @(negedge clk); #1 por_n = 1'b0;
    idle(2);
    @(negedge clk); #1 por_n = 1'b1;
    idle(4);
    peek(A_CTRL, v); chk("R11 power-on aborts", v, 8'h00);
    idle(4);
    summary();
  end
endmodule